// File: doc/BRIEF.md
# Receive Character Buffer with Trigger Interrupt

This block sits between a serial receiver's framer and the host side of a UART channel. Each character that the framer finishes is pushed in together with a 3-bit error tag, which records problems such as parity, framing or break. The host pops one character for each read strobe. The entry at the head of the queue is always visible on the read outputs. Its data and its tag are shown together, so status logic can report errors for the character that is about to be read.

Two host-facing signals summarise the occupancy. A data-ready flag stays high from the first stored character until the queue drains. A level interrupt is high whenever the number of stored characters is at or above a threshold chosen by a 2-bit select. The interrupt follows the count: it drops when reads bring the count below the threshold and rises again when writes bring it back up. Writing into a full buffer loses the character and latches an overrun flag. A flush input empties the buffer in one cycle.

Top module: `rx_char_buffer`

## Requirements
- R1: Each entry holds 8 data bits (`wr_data`) and 3 tag bits (`wr_tag`). `rd_data` and `head_tag` always show the oldest stored entry. Entries leave in the order they arrived.
- R2: The capacity is 2**DEPTH_LOG2 entries (16 by default, 64 with DEPTH_LOG2=6). `level` gives the stored count in the cycle after each write or read edge.
- R3: `data_ready` goes high in the cycle after a write into an empty buffer. It stays high until the count returns to zero.
- R4: `trig_sel` chooses the threshold: 0 selects 1 entry, 1 selects DEPTH/4, 2 selects DEPTH/2 and 3 selects DEPTH-2. For the 16-deep case these are 1, 4, 8 and 14.
- R5: `trig_irq` is high exactly when `level` is at or above the selected threshold. It changes in the same cycle as `level`.
- R6: Writes are still accepted while `trig_irq` is high. After a read drops the count below the threshold, a write that brings it back raises `trig_irq` again.
- R7: A write to a full buffer without a read in the same cycle is dropped. It leaves the count and the contents unchanged and sets `overrun` in the next cycle.
- R8: `overrun` stays set until a cycle with `status_rd` high, and it is low in the following cycle. If a dropped write coincides with `status_rd`, `overrun` stays set.
- R9: A read strobe on an empty buffer has no effect. A read and a write in the same cycle on a full buffer both take effect: the count stays at DEPTH and no overrun is raised.
- R10: `flush` empties the buffer in the next cycle. It takes priority over a write or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the buffer |
| wr_en | input | 1 | Push strobe from the framer |
| wr_data | input | 8 | Received character |
| wr_tag | input | 3 | Error tag of the received character |
| rd_en | input | 1 | Host pop strobe |
| status_rd | input | 1 | Host status read; clears overrun |
| trig_sel | input | 2 | Threshold select |
| rd_data | output | 8 | Data of head entry |
| head_tag | output | 3 | Error tag of head entry |
| data_ready | output | 1 | At least one character stored |
| trig_irq | output | 1 | Count at or above threshold |
| overrun | output | 1 | Sticky dropped-write flag |
| level | output | DEPTH_LOG2+1 | Stored character count |

## Verification
A host pop can coincide with a framer push while the buffer is full. That cycle decides whether the character is stored or lost as an overrun. The bench fills the buffer to capacity and strobes both in the same cycle. It then checks that the count stays at the maximum, that no overrun appears, and that the new character comes out last. A similar collision of an overrun event with a host status read is provoked. There the flag must remain set. A long pseudo-random run mixes all strobes against an arithmetic model of count, order and threshold.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, the stored entry type and the threshold rule.
// Assumes an 8-bit character and a 3-bit error tag per entry.
package rxb_pkg;

    localparam int DATA_W  = 8;
    localparam int TAG_W   = 3;
    localparam int ENTRY_W = DATA_W + TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Threshold for a select code, scaled to the buffer depth.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
// Circular storage for received entries with read and write pointers.
// Assumes push and pop are already qualified: push never targets a slot
// that still holds data, except the head slot being popped in the same cycle.
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  logic      pop,
    input  rx_entry_t wr_entry,
    output rx_entry_t head_entry
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    rx_entry_t             mem [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_ptr;
    logic [DEPTH_LOG2-1:0] rd_ptr;

    // Write the incoming entry into the slot at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Advance the pointers, which wrap by their width; flush rewinds them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Present the oldest entry without waiting for a read.
    always_comb head_entry = mem[rd_ptr];

endmodule

// File: rtl/rxb_ctrl.sv
`timescale 1ns/1ps
// Occupancy control: qualifies strobes into push, pop and drop, and keeps
// the stored count. Assumes flush wins over any strobe in the same cycle.
module rxb_ctrl #(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic                push,
    output logic                pop,
    output logic                drop,
    output logic [DEPTH_LOG2:0] count
);

    localparam int CNT_W = DEPTH_LOG2 + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << DEPTH_LOG2);

    logic empty;
    logic full;

    // Decode the count into its two boundary states.
    always_comb begin
        empty = (count == '0);
        full  = (count == FULL_CNT);
    end

    // Qualify strobes; a pop frees the slot a simultaneous push needs.
    always_comb begin
        pop  = rd_en && !empty && !flush;
        push = wr_en && !flush && (!full || pop);
        drop = wr_en && !flush && full && !pop;
    end

    // Track the stored count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxb_irq.sv
`timescale 1ns/1ps
// Host indications derived from the count: data ready and the level
// interrupt against the selected threshold. Purely combinational.
module rxb_irq
    import rxb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic [DEPTH_LOG2:0] count,
    input  logic [1:0]          trig_sel,
    output logic                data_ready,
    output logic                trig_irq
);

    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int CNT_W = DEPTH_LOG2 + 1;

    logic [CNT_W-1:0] thr;

    // Select the threshold for the current configuration.
    always_comb thr = CNT_W'(trig_level(trig_sel, DEPTH));

    // Compare the count against empty and against the threshold.
    always_comb begin
        data_ready = (count != '0);
        trig_irq   = (count >= thr);
    end

endmodule

// File: rtl/rxb_overrun.sv
`timescale 1ns/1ps
// Sticky overrun flag. A new drop wins over a clearing status read.
module rxb_overrun (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic status_rd,
    output logic overrun
);

    // Latch a dropped write and clear the flag on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (status_rd) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_char_buffer.sv
`timescale 1ns/1ps
// Receive character buffer: tagged queue, occupancy control, threshold
// interrupt and overrun flag. Assumes one push and one pop strobe per cycle.
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  rd_en,
    input  logic                  status_rd,
    input  logic [1:0]            trig_sel,
    output logic [DATA_W-1:0]     rd_data,
    output logic [TAG_W-1:0]      head_tag,
    output logic                  data_ready,
    output logic                  trig_irq,
    output logic                  overrun,
    output logic [DEPTH_LOG2:0]   level
);

    logic      push;
    logic      pop;
    logic      drop;
    rx_entry_t wr_entry;
    rx_entry_t head_entry;

    // Pack the incoming character and its tag into one entry.
    always_comb begin
        wr_entry.data = wr_data;
        wr_entry.tag  = wr_tag;
    end

    rxb_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .push  (push),
        .pop   (pop),
        .drop  (drop),
        .count (level)
    );

    rxb_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (push),
        .pop        (pop),
        .wr_entry   (wr_entry),
        .head_entry (head_entry)
    );

    rxb_irq #(.DEPTH_LOG2(DEPTH_LOG2)) u_irq (
        .count      (level),
        .trig_sel   (trig_sel),
        .data_ready (data_ready),
        .trig_irq   (trig_irq)
    );

    rxb_overrun u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop      (drop),
        .status_rd (status_rd),
        .overrun   (overrun)
    );

    // Split the head entry onto the host outputs.
    always_comb begin
        rd_data  = head_entry.data;
        head_tag = head_entry.tag;
    end

endmodule

// File: rtl/rxb_checker.sv
`timescale 1ns/1ps
// Property checker for rx_char_buffer, attached by bind below.
module rxb_checker #(
    parameter int DEPTH_LOG2 = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic                wr_en,
    input logic                rd_en,
    input logic                status_rd,
    input logic [1:0]          trig_sel,
    input logic                data_ready,
    input logic                trig_irq,
    input logic                overrun,
    input logic [DEPTH_LOG2:0] level
);

    localparam int CNT_W = DEPTH_LOG2 + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << DEPTH_LOG2);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT); // R2

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && !flush && level != '0 |=> level == $past(level) - 1'b1); // R2

    AST_READY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flush && level == '0 |=> data_ready); // R3

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready && !flush && !rd_en |=> data_ready); // R3

    AST_SEL0_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        trig_sel == 2'd0 |-> trig_irq == (level != '0)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_en && !flush && level == FULL_CNT |=> overrun && level == FULL_CNT); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !status_rd |=> overrun); // R8

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && !flush && level == '0 |=> level == '0); // R9

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0 && !data_ready); // R10

endmodule

bind rx_char_buffer rxb_checker #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .status_rd  (status_rd),
    .trig_sel   (trig_sel),
    .data_ready (data_ready),
    .trig_irq   (trig_irq),
    .overrun    (overrun),
    .level      (level)
);

// File: tb/rx_char_buffer_tb.sv
`timescale 1ns/1ps
module rx_char_buffer_tb;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_tag = '0;
    logic       rd_en = 1'b0;
    logic       status_rd = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [7:0] rd_data;
    logic [2:0] head_tag;
    logic       data_ready;
    logic       trig_irq;
    logic       overrun;
    logic [4:0] level;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_data [D];
    logic [2:0] m_tag  [D];
    int         m_cnt  = 0;
    int         m_head = 0;
    bit         m_ovr  = 0;

    always #2.5 clk = ~clk;

    rx_char_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .wr_data(wr_data), .wr_tag(wr_tag), .rd_en(rd_en),
        .status_rd(status_rd), .trig_sel(trig_sel), .rd_data(rd_data),
        .head_tag(head_tag), .data_ready(data_ready), .trig_irq(trig_irq),
        .overrun(overrun), .level(level)
    );

    function automatic int thr_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? D / 4 : (s == 2'd2) ? D / 2 : D - 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 level", int'(level), m_cnt);
        chk("R3 data_ready", int'(data_ready), int'(m_cnt != 0));
        chk("R5 trig_irq", int'(trig_irq), int'(m_cnt >= thr_of(trig_sel)));
        chk("R8 overrun", int'(overrun), int'(m_ovr));
        if (m_cnt > 0) begin
            chk("R1 head data", int'(rd_data), int'(m_data[m_head]));
            chk("R1 head tag", int'(head_tag), int'(m_tag[m_head]));
        end
    endtask

    // One clock with the given strobes; the model then advances and all outputs are compared.
    task automatic step(input bit w, input bit r, input bit f, input bit s,
                        input logic [7:0] d, input logic [2:0] t);
        bit pop_ok;
        bit push_ok;
        wr_en = w; rd_en = r; flush = f; status_rd = s; wr_data = d; wr_tag = t;
        @(posedge clk);
        #1;
        if (f) begin
            m_cnt = 0; m_head = 0;
            if (s) m_ovr = 0;
        end else begin
            pop_ok  = r && (m_cnt > 0);
            push_ok = w && ((m_cnt < D) || pop_ok);
            if (push_ok) begin
                m_data[(m_head + m_cnt) % D] = d;
                m_tag[(m_head + m_cnt) % D]  = t;
            end
            if (w && !push_ok) m_ovr = 1;
            else if (s) m_ovr = 0;
            if (pop_ok) m_head = (m_head + 1) % D;
            m_cnt = m_cnt + int'(push_ok) - int'(pop_ok);
        end
        wr_en = 0; rd_en = 0; flush = 0; status_rd = 0;
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R2 reset level", int'(level), 0);
        chk("R3 reset ready", int'(data_ready), 0);
        chk("R5 reset irq", int'(trig_irq), 0);
        chk("R8 reset overrun", int'(overrun), 0);

        // Full sweep of every threshold: fill, overflow, clear, drain.
        for (int sel = 0; sel < 4; sel++) begin
            trig_sel = 2'(sel);
            step(0, 0, 1, 0, 8'h00, 3'd0);
            for (int i = 0; i < D; i++) begin
                step(1, 0, 0, 0, 8'((sel * 37 + i * 11) ^ 8'h5A), 3'(i + sel));
                if (i + 1 == thr_of(2'(sel)))
                    chk("R4 irq at threshold", int'(trig_irq), 1);
                if (i + 2 == thr_of(2'(sel)))
                    chk("R4 irq one below", int'(trig_irq), 0);
            end
            step(1, 0, 0, 0, 8'hEE, 3'd7);
            chk("R7 full write dropped level", int'(level), D);
            chk("R7 overrun set", int'(overrun), 1);
            chk("R7 head unchanged", int'(rd_data), int'(8'((sel * 37) ^ 8'h5A)));
            step(0, 0, 0, 0, 8'h00, 3'd0);
            chk("R8 overrun held", int'(overrun), 1);
            step(0, 0, 0, 1, 8'h00, 3'd0);
            chk("R8 overrun cleared", int'(overrun), 0);
            for (int i = 0; i < D; i++) step(0, 1, 0, 0, 8'h00, 3'd0);
            step(0, 1, 0, 0, 8'h00, 3'd0);
            chk("R9 empty read ignored", int'(level), 0);
        end

        // Re-arm of the level interrupt around a threshold of four.
        trig_sel = 2'd1;
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 8'(i + 100), 3'(i));
        chk("R6 irq pending", int'(trig_irq), 1);
        step(1, 0, 0, 0, 8'd104, 3'd4);
        chk("R6 write accepted while pending", int'(level), 5);
        step(0, 1, 0, 0, 8'h00, 3'd0);
        step(0, 1, 0, 0, 8'h00, 3'd0);
        chk("R6 irq cleared below", int'(trig_irq), 0);
        step(1, 0, 0, 0, 8'd105, 3'd5);
        chk("R6 irq re-asserted", int'(trig_irq), 1);

        // Same-cycle push and pop on a full buffer.
        step(0, 0, 1, 0, 8'h00, 3'd0);
        for (int i = 0; i < D; i++) step(1, 0, 0, 0, 8'(i + 1), 3'(i));
        step(1, 1, 0, 0, 8'hC3, 3'd6);
        chk("R9 full push+pop level", int'(level), D);
        chk("R9 full push+pop no overrun", int'(overrun), 0);
        chk("R9 head advanced", int'(rd_data), 2);
        // Overrun coinciding with a status read.
        step(1, 0, 0, 1, 8'h11, 3'd1);
        chk("R8 drop beats clear", int'(overrun), 1);
        step(0, 0, 0, 1, 8'h00, 3'd0);
        for (int i = 0; i < D - 1; i++) step(0, 1, 0, 0, 8'h00, 3'd0);
        chk("R1 newest last", int'(rd_data), 8'hC3);
        chk("R1 newest tag", int'(head_tag), 6);

        // Flush against simultaneous strobes.
        step(1, 0, 0, 0, 8'h22, 3'd2);
        step(1, 1, 1, 0, 8'h33, 3'd3);
        chk("R10 flush wins", int'(level), 0);
        chk("R10 ready low", int'(data_ready), 0);

        // Pseudo-random mix of all strobes and selects.
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[11:8] == 4'h0) trig_sel = lfsr[1:0];
            step(lfsr[0] | lfsr[5], lfsr[2] & lfsr[7], lfsr[15:9] == 7'h00,
                 lfsr[14:12] == 3'b101, lfsr[7:0] ^ lfsr[15:8], lfsr[4:2]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule